// File: doc/BRIEF.md
# DMA Stream Double-Buffer Controller

This block is the control core of a single DMA stream. It keeps the stream configuration, a programmed item count, a peripheral base address and two memory base addresses. Once enabled, it answers peripheral requests one item at a time. For each accepted item it presents a read/write address pair for a downstream bus master and returns an acknowledge to the peripheral. Memory-to-memory streams run without waiting for a request.

Three run modes are available. Normal mode stops the stream when the count is used up. Circular mode reloads the count and restarts both addresses. Double-buffer mode does the same and also swaps between the two memory base registers at every completion. A current-target bit shows which memory register is in use. Software may rewrite the other one while the stream runs.

A disable request never cuts an item short. The enable bit keeps reading 1 until the stream has really stopped. Every item completion raises a one-cycle pulse. The live item count and the matching byte count are always visible on ports. Registers are written through a simple write strobe and read back one cycle after the address is presented.

Top module: `dma_dbuf_stream`

## Requirements
- R1: After reset the enable bit, all configuration fields, the live count, `xfer_valid`, `per_ack` and `tc_pulse` are 0, and every register reads 0.
- R2: The configuration register (offset 0) has these fields: bit 0 enable, bits 7:6 direction, bit 8 circular, bit 9 peripheral increment, bit 10 memory increment, bits 12:11 peripheral size, bits 14:13 memory size, bit 18 double-buffer, bit 19 current target. Direction codes are 0 peripheral-to-memory, 1 memory-to-peripheral and 2 memory-to-memory. Size codes are 0 byte, 1 half-word and 2 word. Register offsets are 1 for the item count, 2 for the peripheral address, 3 for memory-0 and 4 for memory-1. Offset 1 reads the live count while the stream is enabled and the programmed count otherwise.
- R3: An enabled stream issues one item per accepted request, at most one item every two cycles, and decrements the live count by one per item. Issuing an item pulses `xfer_valid` for one cycle together with the address pair. For directions 0 and 2 the read address is the peripheral-side pointer and the write address is the memory pointer. Direction 1 swaps the two. Direction 2 ignores `per_req` and never pulses `per_ack`. Directions 0 and 1 pulse `per_ack` with each item.
- R4: With its increment bit set, a pointer advances by 1, 2 or 4 bytes per item for size code 0, 1 or 2. With the bit clear, the pointer stays at its base address.
- R5: The item that takes the live count from 1 to 0 comes with a one-cycle `tc_pulse`. In normal mode the enable bit then clears and the live count stays at 0.
- R6: In circular mode, completion reloads the live count from the programmed count, returns both pointers to their base registers and keeps the stream enabled.
- R7: In double-buffer mode each completion toggles the current-target bit. The memory pointer then restarts from memory-1 when the new bit is 1 and from memory-0 when it is 0. At enable, the pointer starts from the register selected by the written bit.
- R8: While a double-buffer stream runs, memory-1 accepts writes while the current-target bit is 0 and memory-0 accepts writes while it is 1. The register in use ignores writes.
- R9: While the stream is enabled, writes to the count and peripheral address are ignored. Memory writes outside the case in R8 are ignored too. Configuration writes that keep bit 0 at 1 change nothing.
- R10: Writing 0 to the enable bit of a running stream stops new items from starting after that write. The enable bit keeps reading 1 until the item in flight has finished. The live count is kept after the stop.
- R11: `remaining_bytes` equals the live count shifted left by the peripheral size code.
- R12: Setting the enable bit while the programmed count is 0 leaves the stream disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register offset for write and read |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data for the offset of the previous cycle |
| per_req | input | 1 | Peripheral request for one item |
| per_ack | output | 1 | One-cycle acknowledge of an issued peripheral item |
| xfer_valid | output | 1 | Address pair valid for one item |
| rd_addr | output | AW | Source address of the issued item |
| wr_addr | output | AW | Destination address of the issued item |
| tc_pulse | output | 1 | One-cycle transfer-complete pulse |
| remaining_items | output | CW | Live item count |
| remaining_bytes | output | CW+2 | Live count in bytes |

## Verification
The assertions check on every cycle the handshake and timing rules: an acknowledge only follows a request, items are at least two cycles apart, completion pulses come with an item, the count drops by exactly one per item, no item starts while the stream is off or a stop is pending, and the target bit flips at every double-buffer completion. Only the bench scenarios can show the address arithmetic across all size and increment combinations, the reload of circular and double-buffer streams, and the write protection of registers while the stream runs. The deferred enable readback after a disable and the refusal to start with a zero count also need those scenarios.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  // configuration bit positions (software decodes these)
  localparam int CFG_EN     = 0;
  localparam int CFG_DIR_LO = 6;
  localparam int CFG_CIRC   = 8;
  localparam int CFG_PINC   = 9;
  localparam int CFG_MINC   = 10;
  localparam int CFG_PSZ_LO = 11;
  localparam int CFG_MSZ_LO = 13;
  localparam int CFG_DBM    = 18;
  localparam int CFG_CT     = 19;

  // register offsets
  localparam int OFS_CFG  = 0;
  localparam int OFS_CNT  = 1;
  localparam int OFS_PER  = 2;
  localparam int OFS_MEM0 = 3;
  localparam int OFS_MEM1 = 4;

  typedef enum logic [1:0] {
    DIR_P2M = 2'd0,
    DIR_M2P = 2'd1,
    DIR_M2M = 2'd2,
    DIR_RSV = 2'd3
  } dir_e;

  typedef struct packed {
    logic       ct;
    logic       dbm;
    logic [1:0] msz;
    logic [1:0] psz;
    logic       minc;
    logic       pinc;
    logic       circ;
    dir_e       dir;
  } cfg_t;

  function automatic logic [2:0] size_step(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] size_shift(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction
endpackage

// File: rtl/dbs_regs.sv
module dbs_regs
  import dbs_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 16,
  parameter int DW   = 32,
  parameter int RA_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [RA_W-1:0] waddr,
  input  logic [DW-1:0]   wdata,
  input  logic            stream_on,
  input  logic            dbm,
  input  logic            ct,
  output logic [CW-1:0]   prog_cnt,
  output logic [AW-1:0]   per_base,
  output logic [AW-1:0]   mem0_base,
  output logic [AW-1:0]   mem1_base
);
  logic idle_wr, mem0_ok, mem1_ok;

  assign idle_wr = we && !stream_on;
  assign mem0_ok = we && (!stream_on || (dbm && ct));
  assign mem1_ok = we && (!stream_on || (dbm && !ct));

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_cnt  <= '0;
      per_base  <= '0;
      mem0_base <= '0;
      mem1_base <= '0;
    end else begin
      if (idle_wr && waddr == RA_W'(OFS_CNT)) prog_cnt  <= wdata[CW-1:0];
      if (idle_wr && waddr == RA_W'(OFS_PER)) per_base  <= wdata[AW-1:0];
      if (mem0_ok && waddr == RA_W'(OFS_MEM0)) mem0_base <= wdata[AW-1:0];
      if (mem1_ok && waddr == RA_W'(OFS_MEM1)) mem1_base <= wdata[AW-1:0];
    end
  end
endmodule

// File: rtl/dbs_seq.sv
module dbs_seq
  import dbs_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  cfg_t          wr_cfg,
  input  logic          wr_en,
  input  logic [CW-1:0] prog_cnt,
  input  logic          per_req,
  output cfg_t          cfg,
  output logic          stream_on,
  output logic          stop_pend,
  output logic          issue,
  output logic          last,
  output logic          start,
  output logic          reload,
  output logic          tgt_sel,
  output logic [CW-1:0] live_cnt
);
  cfg_t          cfg_q;
  logic          en_q, busy_q, stop_q;
  logic [CW-1:0] live_q;

  assign start   = cfg_we && !en_q && wr_en && (prog_cnt != '0);
  assign issue   = en_q && !busy_q && !stop_q && (per_req || cfg_q.dir == DIR_M2M);
  assign last    = issue && (live_q == CW'(1));
  assign reload  = last && (cfg_q.circ || cfg_q.dbm);
  // memory register picked for the next (re)start of the memory pointer
  assign tgt_sel = start ? (wr_cfg.dbm & wr_cfg.ct) : (cfg_q.dbm & ~cfg_q.ct);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      en_q   <= 1'b0;
      busy_q <= 1'b0;
      stop_q <= 1'b0;
      live_q <= '0;
    end else begin
      busy_q <= issue;
      if (cfg_we && !en_q) begin
        cfg_q <= wr_cfg;
        if (start) begin
          en_q   <= 1'b1;
          live_q <= prog_cnt;
        end
      end else if (cfg_we && en_q && !wr_en) begin
        stop_q <= 1'b1;
      end
      if (issue) begin
        if (last) begin
          if (cfg_q.circ || cfg_q.dbm) begin
            live_q <= prog_cnt;
            if (cfg_q.dbm) cfg_q.ct <= ~cfg_q.ct;
          end else begin
            live_q <= '0;
            en_q   <= 1'b0;
          end
        end else begin
          live_q <= live_q - CW'(1);
        end
      end
      if (stop_q && en_q && !busy_q) begin
        en_q   <= 1'b0;
        stop_q <= 1'b0;
      end
      if (stop_q && !en_q) stop_q <= 1'b0;
    end
  end

  assign cfg       = cfg_q;
  assign stream_on = en_q;
  assign stop_pend = stop_q;
  assign live_cnt  = live_q;
endmodule

// File: rtl/dbs_ptr.sv
module dbs_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          step_en,
  input  logic [2:0]    step,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)          ptr <= '0;
    else if (load)    ptr <= base;
    else if (step_en) ptr <= ptr + AW'(step);
  end
endmodule

// File: rtl/dma_dbuf_stream.sv
module dma_dbuf_stream
  import dbs_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 16,
  parameter int DW   = 32,
  parameter int RA_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            per_req,
  output logic            per_ack,
  output logic            xfer_valid,
  output logic [AW-1:0]   rd_addr,
  output logic [AW-1:0]   wr_addr,
  output logic            tc_pulse,
  output logic [CW-1:0]   remaining_items,
  output logic [CW+1:0]   remaining_bytes
);
  localparam int NPTR    = 2;
  localparam int PTR_PER = 0;
  localparam int PTR_MEM = 1;

  cfg_t          cfg, wr_cfg;
  logic          cfg_we, stream_on, stop_pend, issue, last, start, reload, tgt_sel;
  logic [CW-1:0] prog_cnt, live_cnt;
  logic [AW-1:0] per_base, mem0_base, mem1_base;
  logic [DW-1:0] cfg_word, rd_mux;

  // write-side decode of the configuration word
  assign cfg_we      = reg_we && reg_addr == RA_W'(OFS_CFG);
  assign wr_cfg.ct   = reg_wdata[CFG_CT];
  assign wr_cfg.dbm  = reg_wdata[CFG_DBM];
  assign wr_cfg.msz  = reg_wdata[CFG_MSZ_LO +: 2];
  assign wr_cfg.psz  = reg_wdata[CFG_PSZ_LO +: 2];
  assign wr_cfg.minc = reg_wdata[CFG_MINC];
  assign wr_cfg.pinc = reg_wdata[CFG_PINC];
  assign wr_cfg.circ = reg_wdata[CFG_CIRC];
  assign wr_cfg.dir  = dir_e'(reg_wdata[CFG_DIR_LO +: 2]);

  dbs_regs #(.AW(AW), .CW(CW), .DW(DW), .RA_W(RA_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .waddr(reg_addr), .wdata(reg_wdata),
    .stream_on(stream_on), .dbm(cfg.dbm), .ct(cfg.ct),
    .prog_cnt(prog_cnt), .per_base(per_base),
    .mem0_base(mem0_base), .mem1_base(mem1_base)
  );

  dbs_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .wr_cfg(wr_cfg),
    .wr_en(reg_wdata[CFG_EN]), .prog_cnt(prog_cnt), .per_req(per_req),
    .cfg(cfg), .stream_on(stream_on), .stop_pend(stop_pend), .issue(issue),
    .last(last), .start(start), .reload(reload), .tgt_sel(tgt_sel),
    .live_cnt(live_cnt)
  );

  // address pointers: one per side, same structure
  logic [AW-1:0] ptr_q    [NPTR];
  logic [AW-1:0] ptr_base [NPTR];
  logic [2:0]    ptr_step [NPTR];
  logic          ptr_inc  [NPTR];

  assign ptr_base[PTR_PER] = per_base;
  assign ptr_base[PTR_MEM] = tgt_sel ? mem1_base : mem0_base;
  assign ptr_step[PTR_PER] = size_step(cfg.psz);
  assign ptr_step[PTR_MEM] = size_step(cfg.msz);
  assign ptr_inc[PTR_PER]  = cfg.pinc;
  assign ptr_inc[PTR_MEM]  = cfg.minc;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    dbs_ptr #(.AW(AW)) u_ptr (
      .clk(clk), .rst(rst), .load(start || reload), .base(ptr_base[g]),
      .step_en(issue && ptr_inc[g] && !reload), .step(ptr_step[g]),
      .ptr(ptr_q[g])
    );
  end

  // read-back mux
  always_comb begin
    cfg_word                    = '0;
    cfg_word[CFG_EN]            = stream_on;
    cfg_word[CFG_DIR_LO +: 2]   = cfg.dir;
    cfg_word[CFG_CIRC]          = cfg.circ;
    cfg_word[CFG_PINC]          = cfg.pinc;
    cfg_word[CFG_MINC]          = cfg.minc;
    cfg_word[CFG_PSZ_LO +: 2]   = cfg.psz;
    cfg_word[CFG_MSZ_LO +: 2]   = cfg.msz;
    cfg_word[CFG_DBM]           = cfg.dbm;
    cfg_word[CFG_CT]            = cfg.ct;
  end

  always_comb begin
    case (reg_addr)
      RA_W'(OFS_CFG):  rd_mux = cfg_word;
      RA_W'(OFS_CNT):  rd_mux = DW'(stream_on ? live_cnt : prog_cnt);
      RA_W'(OFS_PER):  rd_mux = DW'(per_base);
      RA_W'(OFS_MEM0): rd_mux = DW'(mem0_base);
      RA_W'(OFS_MEM1): rd_mux = DW'(mem1_base);
      default:         rd_mux = '0;
    endcase
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_valid <= 1'b0;
      per_ack    <= 1'b0;
      tc_pulse   <= 1'b0;
      rd_addr    <= '0;
      wr_addr    <= '0;
      reg_rdata  <= '0;
    end else begin
      xfer_valid <= issue;
      per_ack    <= issue && cfg.dir != DIR_M2M;
      tc_pulse   <= last;
      reg_rdata  <= rd_mux;
      if (issue) begin
        if (cfg.dir == DIR_M2P) begin
          rd_addr <= ptr_q[PTR_MEM];
          wr_addr <= ptr_q[PTR_PER];
        end else begin
          rd_addr <= ptr_q[PTR_PER];
          wr_addr <= ptr_q[PTR_MEM];
        end
      end
    end
  end

  assign remaining_items = live_cnt;
  assign remaining_bytes = (CW+2)'(live_cnt) << size_shift(cfg.psz);
endmodule

// File: rtl/dbs_chk.sv
module dbs_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          per_req,
  input logic          per_ack,
  input logic          xfer_valid,
  input logic          tc_pulse,
  input logic [CW-1:0] remaining_items,
  input logic          stream_on,
  input logic          stop_pend,
  input logic          dbm,
  input logic          ct
);
  // R3: an acknowledge answers a request seen at the issuing edge
  p_ack_after_req_r3: assert property (@(posedge clk) disable iff (rst)
    per_ack |-> $past(per_req));

  // R3: items are at least two cycles apart
  p_item_gap_r3: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |=> !xfer_valid);

  // R3: each non-final item lowers the live count by exactly one
  p_count_dec_r3: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !tc_pulse) |-> remaining_items == $past(remaining_items) - CW'(1));

  // R5: completion comes with an item
  p_tc_on_item_r5: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |-> xfer_valid);

  // R10: nothing starts while off or while a stop is pending
  p_no_item_off_r10: assert property (@(posedge clk) disable iff (rst)
    (!stream_on || stop_pend) |=> !xfer_valid);

  // R7: double-buffer completion flips the target
  p_ct_flip_r7: assert property (@(posedge clk) disable iff (rst)
    (tc_pulse && dbm) |-> ct != $past(ct));
endmodule

bind dma_dbuf_stream dbs_chk #(.CW(CW)) u_dbs_chk (
  .clk(clk), .rst(rst), .per_req(per_req), .per_ack(per_ack),
  .xfer_valid(xfer_valid), .tc_pulse(tc_pulse),
  .remaining_items(remaining_items), .stream_on(stream_on),
  .stop_pend(stop_pend), .dbm(cfg.dbm), .ct(cfg.ct)
);

// File: tb/test_dma_dbuf_stream.sv
module test_dma_dbuf_stream;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, CW = 16, DW = 32, RA_W = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            reg_we = 1'b0;
  logic [RA_W-1:0] reg_addr = '0;
  logic [DW-1:0]   reg_wdata = '0;
  logic [DW-1:0]   reg_rdata;
  logic            per_req = 1'b0;
  logic            per_ack, xfer_valid, tc_pulse;
  logic [AW-1:0]   rd_addr, wr_addr;
  logic [CW-1:0]   remaining_items;
  logic [CW+1:0]   remaining_bytes;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_dbuf_stream #(.AW(AW), .CW(CW), .DW(DW), .RA_W(RA_W)) i_dma_dbuf_stream (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req),
    .per_ack(per_ack), .xfer_valid(xfer_valid), .rd_addr(rd_addr),
    .wr_addr(wr_addr), .tc_pulse(tc_pulse),
    .remaining_items(remaining_items), .remaining_bytes(remaining_bytes)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input bit en, input int dir, input bit circ,
                                         input bit pinc, input bit minc, input int psz,
                                         input int msz, input bit dbm, input bit ct);
    logic [31:0] w;
    w = '0;
    w[0] = en; w[7:6] = dir[1:0]; w[8] = circ; w[9] = pinc; w[10] = minc;
    w[12:11] = psz[1:0]; w[14:13] = msz[1:0]; w[18] = dbm; w[19] = ct;
    return w;
  endfunction

  // entered and left at a falling edge
  task automatic wr_reg(input int a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = RA_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input int a, output logic [31:0] d);
    reg_addr = RA_W'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic next_item(input bit req_val, input bit drop,
                           output logic [31:0] ra, output logic [31:0] wa,
                           output bit tc, output bit ack,
                           output logic [15:0] rem, output logic [17:0] rb);
    int w;
    w = 0;
    per_req = req_val;
    while (!xfer_valid && w < 40) begin
      @(negedge clk);
      w++;
    end
    if (!xfer_valid) begin
      n_chk++; n_bad++;
      $display("FAIL R3 item not issued actual=0 expected=1");
    end
    ra = rd_addr; wa = wr_addr; tc = tc_pulse; ack = per_ack;
    rem = remaining_items; rb = remaining_bytes;
    if (drop) per_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R3 watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, ra, wa, ep, em;
    logic [15:0] rem, rem0;
    logic [17:0] rb;
    bit tc, ack;
    bit seen;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 xfer_valid", xfer_valid, 0);
    check("R1 tc_pulse", tc_pulse, 0);
    check("R1 per_ack", per_ack, 0);
    check("R1 remaining_items", remaining_items, 0);
    rd_reg(0, d); check("R1 cfg reads 0", d, 0);
    rd_reg(1, d); check("R1 count reads 0", d, 0);

    // R12 enabling with zero count
    wr_reg(1, 0);
    wr_reg(0, mk_cfg(1, 0, 0, 1, 1, 0, 0, 0, 0));
    rd_reg(0, d); check("R12 enable stays 0", d[0], 0);
    per_req = 1'b1;
    seen = 0;
    repeat (6) begin @(negedge clk); if (xfer_valid) seen = 1; end
    per_req = 1'b0;
    check("R12 no item issued", seen, 0);

    // R2 R3 R4 R5 R11: normal peripheral-to-memory sweep
    for (int psz = 0; psz < 3; psz++)
      for (int msz = 0; msz < 3; msz++)
        for (int pi = 0; pi < 2; pi++)
          for (int mi = 0; mi < 2; mi++) begin
            wr_reg(1, 3);
            wr_reg(2, 32'h4000_0000 + psz * 32'h100);
            wr_reg(3, 32'h2000_0000 + msz * 32'h100);
            wr_reg(0, mk_cfg(1, 0, 0, pi[0], mi[0], psz, msz, 0, 0));
            rd_reg(0, d);
            check("R2 cfg readback", d, mk_cfg(1, 0, 0, pi[0], mi[0], psz, msz, 0, 0));
            for (int k = 0; k < 3; k++) begin
              next_item(1, k == 2, ra, wa, tc, ack, rem, rb);
              ep = 32'h4000_0000 + psz * 32'h100 + (pi ? k * (1 << psz) : 0);
              em = 32'h2000_0000 + msz * 32'h100 + (mi ? k * (1 << msz) : 0);
              check("R4 peripheral address", ra, ep);
              check("R4 memory address", wa, em);
              check("R3 per_ack", ack, 1);
              check("R3 live count", rem, 2 - k);
              check("R11 byte count", rb, (2 - k) << psz);
              check("R5 tc on last only", tc, k == 2);
            end
            rd_reg(0, d); check("R5 enable clears", d[0], 0);
            check("R5 count at 0", remaining_items, 0);
          end

    // R3 memory-to-peripheral swaps the pair
    wr_reg(1, 2); wr_reg(2, 32'h0000_0A00); wr_reg(3, 32'h0000_0B00);
    wr_reg(0, mk_cfg(1, 1, 0, 0, 1, 2, 1, 0, 0));
    for (int k = 0; k < 2; k++) begin
      next_item(1, k == 1, ra, wa, tc, ack, rem, rb);
      check("R3 m2p read is memory", ra, 32'h0B00 + 2 * k);
      check("R3 m2p write is peripheral", wa, 32'h0A00);
      check("R11 word bytes", rb, (1 - k) * 4);
    end

    // R3 memory-to-memory runs without request and never acknowledges
    wr_reg(1, 4); wr_reg(2, 32'h0000_1000); wr_reg(3, 32'h0000_8000);
    wr_reg(0, mk_cfg(1, 2, 0, 1, 1, 2, 2, 0, 0));
    for (int k = 0; k < 4; k++) begin
      next_item(0, 0, ra, wa, tc, ack, rem, rb);
      check("R3 m2m source", ra, 32'h1000 + 4 * k);
      check("R3 m2m destination", wa, 32'h8000 + 4 * k);
      check("R3 m2m no ack", ack, 0);
    end
    repeat (3) @(negedge clk);
    rd_reg(0, d); check("R5 m2m finished", d[0], 0);

    // R6 circular reload
    wr_reg(1, 2); wr_reg(2, 32'h100); wr_reg(3, 32'h200);
    wr_reg(0, mk_cfg(1, 0, 1, 1, 1, 0, 0, 0, 0));
    for (int k = 0; k < 5; k++) begin
      next_item(1, k == 4, ra, wa, tc, ack, rem, rb);
      check("R6 peripheral restart", ra, 32'h100 + (k % 2));
      check("R6 memory restart", wa, 32'h200 + (k % 2));
      check("R6 count reload", rem, (k % 2 == 0) ? 1 : 2);
      check("R6 tc per pass", tc, k % 2 == 1);
    end
    rd_reg(0, d); check("R6 still enabled", d[0], 1);

    // R10 deferred disable
    per_req = 1'b1;
    wr_reg(0, mk_cfg(0, 0, 1, 1, 1, 0, 0, 0, 0));
    rd_reg(0, d); check("R10 enable reads 1 after write", d[0], 1);
    rem0 = remaining_items;
    seen = 0;
    repeat (6) begin
      @(negedge clk);
      if (xfer_valid) seen = 1;
    end
    per_req = 1'b0;
    check("R10 no item after stop", seen, 0);
    check("R10 count kept", remaining_items, rem0);
    check("R11 bytes after stop", remaining_bytes, 18'(rem0));
    rd_reg(0, d); check("R10 enable finally 0", d[0], 0);

    // R7 R8 R9 double buffer
    wr_reg(1, 2); wr_reg(2, 32'h80); wr_reg(3, 32'h1000); wr_reg(4, 32'h2000);
    wr_reg(0, mk_cfg(1, 0, 0, 0, 1, 0, 0, 1, 0));
    wr_reg(3, 32'h5000);
    wr_reg(4, 32'h3000);
    wr_reg(1, 9);
    wr_reg(2, 32'h99);
    wr_reg(0, mk_cfg(1, 1, 1, 1, 0, 2, 2, 1, 1));
    rd_reg(3, d); check("R8 in-use memory-0 protected", d, 32'h1000);
    rd_reg(4, d); check("R8 idle memory-1 writable", d, 32'h3000);
    rd_reg(1, d); check("R9 count write ignored", d, 2);
    rd_reg(2, d); check("R9 peripheral write ignored", d, 32'h80);
    rd_reg(0, d); check("R9 config fields kept", d, mk_cfg(1, 0, 0, 0, 1, 0, 0, 1, 0));
    for (int k = 0; k < 2; k++) begin
      next_item(1, k == 1, ra, wa, tc, ack, rem, rb);
      check("R7 first buffer", wa, 32'h1000 + k);
      check("R7 peripheral fixed", ra, 32'h80);
    end
    rd_reg(0, d); check("R7 target toggled to 1", d[19], 1);
    wr_reg(3, 32'h4000);
    wr_reg(4, 32'h7777);
    rd_reg(4, d); check("R8 in-use memory-1 protected", d, 32'h3000);
    rd_reg(3, d); check("R8 idle memory-0 writable", d, 32'h4000);
    for (int k = 0; k < 2; k++) begin
      next_item(1, k == 1, ra, wa, tc, ack, rem, rb);
      check("R7 second buffer", wa, 32'h3000 + k);
      check("R7 tc at buffer end", tc, k == 1);
    end
    rd_reg(0, d); check("R7 target toggled to 0", d[19], 0);
    for (int k = 0; k < 2; k++) begin
      next_item(1, k == 1, ra, wa, tc, ack, rem, rb);
      check("R7 rewritten buffer", wa, 32'h4000 + k);
    end
    wr_reg(0, mk_cfg(0, 0, 0, 0, 1, 0, 0, 1, 0));
    repeat (4) @(negedge clk);
    rd_reg(0, d); check("R10 double-buffer stream stopped", d[0], 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule